// File: doc/BRIEF.md
# Rate-1/2 Tail-Flushed Convolutional Encoder

This block protects a serial bit stream with a rate one-half convolutional code of constraint length nine. Each information bit is combined with the eight bits that came before it. Two parity symbols come out of it, and both leave the block on one serial line at twice the input bit rate. A single master clock drives everything. An internal divider makes a symbol-rate strobe and a bit-rate strobe, and the block exports both so that the data source knows when its bit is sampled.

A frame is a run of information bits, and a frame-end request closes it. When the request arrives, the encoder feeds eight zero bits of its own into the register. This drives the encoder memory back to the all-zero state, so the next frame begins from a known state. While this flush runs, the busy flag is high and the source is ignored. Slots in which the source offers no bit produce no symbols and leave the encoder memory untouched.

Top module: `fec_half_rate_enc`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `code_out`, `code_valid` and `busy` are 0 and neither strobe is asserted.
- R2: `sym_strobe` is high for one cycle every `SYM_DIV` master cycles. The first pulse falls on cycle index `SYM_DIV-1` after reset is released. `bit_strobe` coincides with every second `sym_strobe` pulse, starting with the first one.
- R3: An input bit is taken on a clock edge where `bit_strobe`, `din_valid` and not-`busy` all hold. On that edge `code_out` takes the first symbol. On the next `sym_strobe` edge it takes the second symbol. Each symbol is held for `SYM_DIV` cycles, and `code_valid` stays high across both. The outputs change only on strobe edges.
- R4: Delay d is the input bit taken d slots earlier. The first symbol is the XOR of the current bit with delays 1, 2, 3, 5, 7 and 8 (generator 753 octal, most significant bit = current bit). The second symbol is the XOR of the current bit with delays 2, 3, 4 and 8 (generator 561 octal).
- R5: The encoder memory is all zero after reset and again at the end of every flush, so every frame is encoded from the zero state.
- R6: Suppose `frame_end` is high on a `bit_strobe` edge while `busy` is low. Then `busy` is 1 from the next cycle. A bit offered on that same edge with `din_valid` is encoded as the last bit of the frame.
- R7: The flush feeds exactly 8 zero bits in the 8 bit slots that follow the frame-end edge, which gives 16 valid symbols. `busy` returns to 0 at the bit strobe edge one slot after the last tail slot.
- R8: While `busy` is 1, `din`, `din_valid` and `frame_end` have no effect on the symbols, on the memory or on the flush length.
- R9: A bit slot in which `busy` is low and `din_valid` is low gives `code_valid` = 0 for that slot and leaves the memory unchanged.
- R10: From the zero state, the bits 1,1,0,1,0 with `frame_end` on the last one produce the serial symbol sequence 11010111000001111111101100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Information bit |
| din_valid | input | 1 | `din` carries a bit for this slot |
| frame_end | input | 1 | Close the frame and start the zero flush |
| sym_strobe | output | 1 | One-cycle pulse at the symbol rate |
| bit_strobe | output | 1 | One-cycle pulse at the bit rate; inputs are sampled on it |
| code_out | output | 1 | Serial code symbol |
| code_valid | output | 1 | `code_out` carries a symbol |
| busy | output | 1 | Flush in progress; inputs ignored |

## Verification
Every 8-bit frame is swept against a model that computes each symbol from an explicit list of delays. A generator tap in the wrong place, or the two symbols swapped on the line, shows up as a wrong symbol somewhere in that sweep. The frames are sent back to back, so an encoder that is not flushed to zero carries state into the next frame and breaks its first symbols. During each flush the bench drives valid bits and further frame-end requests. A design that listened to them would print data symbols into the tail or lengthen the flush. Idle slots inside a frame check that `code_valid` drops and that the memory does not shift. A memory that shifted would corrupt the symbols after the gap.

// File: rtl/fec_enc_pkg.sv
package fec_enc_pkg;

  localparam int CONSTRAINT_LEN = 9;
  localparam int MEM_W          = CONSTRAINT_LEN - 1;
  localparam int TAIL_LEN       = MEM_W;
  localparam int NUM_GEN        = 2;

  // Tap masks, MSB = current bit, LSB = bit delayed by MEM_W slots
  localparam logic [CONSTRAINT_LEN-1:0] POLY_A_DEF = 9'o753;
  localparam logic [CONSTRAINT_LEN-1:0] POLY_B_DEF = 9'o561;

  typedef enum logic [1:0] {
    FR_OPEN  = 2'd0,
    FR_FLUSH = 2'd1,
    FR_DRAIN = 2'd2
  } frame_phase_e;

  typedef struct packed {
    logic first;
    logic second;
  } sym_pair_t;

  // Modulo-2 sum of the window bits selected by a tap mask
  function automatic logic tap_parity(
    input logic [CONSTRAINT_LEN-1:0] window,
    input logic [CONSTRAINT_LEN-1:0] poly
  );
    return ^(window & poly);
  endfunction

  // New bit enters at the top, oldest bit drops off the bottom
  function automatic logic [MEM_W-1:0] mem_advance(
    input logic             bit_in,
    input logic [MEM_W-1:0] mem
  );
    return {bit_in, mem[MEM_W-1:1]};
  endfunction

endpackage

// File: rtl/fec_enc_strobe.sv
module fec_enc_strobe #(
  parameter int SYM_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic sym_tick,
  output logic bit_tick
);

  logic wrap;
  logic half_q;

  generate
    if (SYM_DIV <= 1) begin : g_full_rate
      assign wrap = 1'b1;
    end else begin : g_divided
      localparam int CW = $clog2(SYM_DIV);
      localparam logic [CW-1:0] LAST = CW'(SYM_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign wrap = (cnt_q == LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
    end else if (wrap) begin
      half_q <= ~half_q;
    end
  end

  assign sym_tick = ~rst & wrap;
  assign bit_tick = sym_tick & ~half_q;

endmodule

// File: rtl/fec_enc_core.sv
module fec_enc_core
  import fec_enc_pkg::*;
#(
  parameter logic [CONSTRAINT_LEN-1:0] POLY_A = POLY_A_DEF,
  parameter logic [CONSTRAINT_LEN-1:0] POLY_B = POLY_B_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             bit_in,
  output sym_pair_t        syms,
  output logic [MEM_W-1:0] mem_q
);

  localparam logic [NUM_GEN-1:0][CONSTRAINT_LEN-1:0] POLYS = {POLY_A, POLY_B};

  logic [CONSTRAINT_LEN-1:0] window;
  logic [NUM_GEN-1:0]        sym_vec;

  assign window = {bit_in, mem_q};

  generate
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      assign sym_vec[g] = tap_parity(window, POLYS[g]);
    end
  endgenerate

  // POLYS[1] is POLY_A (first on the line), POLYS[0] is POLY_B
  assign syms.first  = sym_vec[1];
  assign syms.second = sym_vec[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
    end else if (adv) begin
      mem_q <= mem_advance(bit_in, mem_q);
    end
  end

endmodule

// File: rtl/fec_enc_serial.sv
module fec_enc_serial
  import fec_enc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      bit_tick,
  input  logic      sym_tick,
  input  logic      load,
  input  sym_pair_t pair,
  output logic      line,
  output logic      line_valid
);

  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line       <= 1'b0;
      line_valid <= 1'b0;
      hold_q     <= 1'b0;
    end else if (bit_tick) begin
      if (load) begin
        line       <= pair.first;
        hold_q     <= pair.second;
        line_valid <= 1'b1;
      end else begin
        line       <= 1'b0;
        hold_q     <= 1'b0;
        line_valid <= 1'b0;
      end
    end else if (sym_tick) begin
      line <= hold_q;
    end
  end

endmodule

// File: rtl/fec_enc_ctrl.sv
module fec_enc_ctrl
  import fec_enc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic din,
  input  logic din_valid,
  input  logic frame_end,
  output logic adv,
  output logic feed_bit,
  output logic busy
);

  localparam int TCW = (TAIL_LEN > 1) ? $clog2(TAIL_LEN) : 1;
  localparam logic [TCW-1:0] TAIL_LAST = TCW'(TAIL_LEN - 1);

  frame_phase_e   phase_q;
  logic [TCW-1:0] tail_q;
  logic           take_data;
  logic           tail_slot;

  assign take_data = (phase_q == FR_OPEN) & din_valid;
  assign tail_slot = (phase_q == FR_FLUSH);
  assign adv       = bit_tick & (take_data | tail_slot);
  assign feed_bit  = tail_slot ? 1'b0 : din;
  assign busy      = (phase_q != FR_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= FR_OPEN;
      tail_q  <= '0;
    end else if (bit_tick) begin
      unique case (phase_q)
        FR_OPEN: begin
          if (frame_end) begin
            phase_q <= FR_FLUSH;
            tail_q  <= '0;
          end
        end
        FR_FLUSH: begin
          if (tail_q == TAIL_LAST) begin
            phase_q <= FR_DRAIN;
          end else begin
            tail_q <= tail_q + 1'b1;
          end
        end
        FR_DRAIN: phase_q <= FR_OPEN;
        default:  phase_q <= FR_OPEN;
      endcase
    end
  end

endmodule

// File: rtl/fec_half_rate_enc.sv
module fec_half_rate_enc
  import fec_enc_pkg::*;
#(
  parameter int                        SYM_DIV = 4,
  parameter logic [CONSTRAINT_LEN-1:0] POLY_A  = POLY_A_DEF,
  parameter logic [CONSTRAINT_LEN-1:0] POLY_B  = POLY_B_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic din_valid,
  input  logic frame_end,
  output logic sym_strobe,
  output logic bit_strobe,
  output logic code_out,
  output logic code_valid,
  output logic busy
);

  logic             shift_en;
  logic             feed_bit;
  sym_pair_t        pair;
  logic [MEM_W-1:0] enc_state;

  fec_enc_strobe #(.SYM_DIV(SYM_DIV)) u_strobe (
    .clk      (clk),
    .rst      (rst),
    .sym_tick (sym_strobe),
    .bit_tick (bit_strobe)
  );

  fec_enc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_strobe),
    .din       (din),
    .din_valid (din_valid),
    .frame_end (frame_end),
    .adv       (shift_en),
    .feed_bit  (feed_bit),
    .busy      (busy)
  );

  fec_enc_core #(.POLY_A(POLY_A), .POLY_B(POLY_B)) u_core (
    .clk    (clk),
    .rst    (rst),
    .adv    (shift_en),
    .bit_in (feed_bit),
    .syms   (pair),
    .mem_q  (enc_state)
  );

  fec_enc_serial u_serial (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_strobe),
    .sym_tick   (sym_strobe),
    .load       (shift_en),
    .pair       (pair),
    .line       (code_out),
    .line_valid (code_valid)
  );

endmodule

// File: rtl/fec_half_rate_enc_chk.sv
module fec_half_rate_enc_chk
  import fec_enc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             sym_strobe,
  input logic             bit_strobe,
  input logic             code_out,
  input logic             code_valid,
  input logic             busy,
  input logic             shift_en,
  input logic [MEM_W-1:0] enc_state
);

  logic [1:0] sym_since_q;
  logic       seen_bit_q;
  logic [4:0] tail_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_since_q <= '0;
      seen_bit_q  <= 1'b0;
    end else if (bit_strobe) begin
      sym_since_q <= '0;
      seen_bit_q  <= 1'b1;
    end else if (sym_strobe && sym_since_q != 2'd3) begin
      sym_since_q <= sym_since_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      tail_seen_q <= '0;
    end else if (shift_en) begin
      tail_seen_q <= tail_seen_q + 1'b1;
    end
  end

  assert_strobe_nest_R2: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> sym_strobe);

  assert_bit_every_second_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_strobe && seen_bit_q) |-> (sym_since_q == 2'd1));

  assert_line_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(sym_strobe) |-> $stable(code_out));

  assert_valid_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_strobe) |-> $stable(code_valid));

  assert_zero_after_flush_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (enc_state == '0));

  assert_busy_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bit_strobe));

  assert_tail_length_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (tail_seen_q == 5'(TAIL_LEN)));

endmodule

bind fec_half_rate_enc fec_half_rate_enc_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sym_strobe (sym_strobe),
  .bit_strobe (bit_strobe),
  .code_out   (code_out),
  .code_valid (code_valid),
  .busy       (busy),
  .shift_en   (shift_en),
  .enc_state  (enc_state)
);

// File: tb/fec_half_rate_enc_bench.sv
module fec_half_rate_enc_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic din_valid = 1'b0;
  logic frame_end = 1'b0;
  logic sym_strobe, bit_strobe, code_out, code_valid, busy;

  int total = 0;
  int fails = 0;

  logic obs[$];
  logic exp_q[$];
  logic prev_sym = 1'b0;

  logic [7:0] m_hist = 8'h00;  // m_hist[0] = delay 1 ... m_hist[7] = delay 8
  logic       m_busy = 1'b0;
  int         m_tail = 0;

  localparam logic [25:0] WORKED = 26'b11010111000001111111101100;

  always #4 clk = ~clk;

  fec_half_rate_enc u_fec_half_rate_enc (
    .clk(clk), .rst(rst), .din(din), .din_valid(din_valid),
    .frame_end(frame_end), .sym_strobe(sym_strobe), .bit_strobe(bit_strobe),
    .code_out(code_out), .code_valid(code_valid), .busy(busy)
  );

  always @(negedge clk) begin
    if (rst) prev_sym = 1'b0;
    else begin
      if (prev_sym && code_valid) obs.push_back(code_out);
      prev_sym = sym_strobe;
    end
  end

  task automatic report;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push_bit(input logic b);
    logic s0, s1;
    s0 = b ^ m_hist[0] ^ m_hist[1] ^ m_hist[2] ^ m_hist[4] ^ m_hist[6] ^ m_hist[7];
    s1 = b ^ m_hist[1] ^ m_hist[2] ^ m_hist[3] ^ m_hist[7];
    exp_q.push_back(s0);
    exp_q.push_back(s1);
    m_hist = {m_hist[6:0], b};
  endtask

  task automatic drive_slot(input logic v, input logic b, input logic fe);
    logic emitted;
    do @(negedge clk); while (!bit_strobe);
    din = b; din_valid = v; frame_end = fe;
    emitted = 1'b0;
    if (!m_busy) begin
      if (v) begin push_bit(b); emitted = 1'b1; end
      if (fe) begin m_busy = 1'b1; m_tail = 8; end
    end else if (m_tail > 0) begin
      push_bit(1'b0); m_tail--; emitted = 1'b1;
    end else begin
      m_busy = 1'b0;
    end
    @(negedge clk);
    din = 1'b0; din_valid = 1'b0; frame_end = 1'b0;
    chk(code_valid == emitted, emitted ? "R3" : "R9", "code_valid after slot",
        code_valid, emitted);
    chk(busy == m_busy, m_busy ? "R6" : "R7", "busy after slot", busy, m_busy);
  endtask

  task automatic finish_frame(input logic garbage);
    while (m_busy) drive_slot(garbage, garbage, garbage);
    drive_slot(1'b0, 1'b0, 1'b0);
  endtask

  task automatic compare_frame(input string req);
    @(posedge clk);
    chk(obs.size() == exp_q.size(), req, "symbol count", obs.size(), exp_q.size());
    for (int i = 0; i < obs.size() && i < exp_q.size(); i++)
      chk(obs[i] == exp_q[i], req, $sformatf("symbol %0d", i), obs[i], exp_q[i]);
    obs.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run incomplete, actual timeout expected finish");
    report();
    $finish;
  end

  initial begin
    int mis_sym, mis_bit;
    repeat (3) @(posedge clk);
    chk(!sym_strobe && !bit_strobe, "R1", "strobes in reset", sym_strobe, 0);
    @(negedge clk);
    rst = 1'b0;
    // R1: first cycle after release
    chk(code_out == 0, "R1", "code_out", code_out, 0);
    chk(code_valid == 0, "R1", "code_valid", code_valid, 0);
    chk(busy == 0, "R1", "busy", busy, 0);

    // R2: strobe pattern over 24 cycles, k counts negedges from release
    mis_sym = 0; mis_bit = 0;
    for (int k = 0; k < 24; k++) begin
      if (k != 0) @(negedge clk);
      if (sym_strobe != ((k % 4) == 3)) mis_sym++;
      if (bit_strobe != ((k % 8) == 3)) mis_bit++;
    end
    chk(mis_sym == 0, "R2", "sym_strobe mismatches", mis_sym, 0);
    chk(mis_bit == 0, "R2", "bit_strobe mismatches", mis_bit, 0);
    obs.delete();

    // R10: worked frame 1,1,0,1,0 with frame end on the last bit
    drive_slot(1, 1, 0); drive_slot(1, 1, 0); drive_slot(1, 0, 0);
    drive_slot(1, 1, 0); drive_slot(1, 0, 1);
    finish_frame(1'b0);
    @(posedge clk);
    chk(obs.size() == 26, "R10", "worked frame length", obs.size(), 26);
    for (int i = 0; i < 26 && i < obs.size(); i++)
      chk(obs[i] == WORKED[25-i], "R10", $sformatf("worked symbol %0d", i),
          obs[i], WORKED[25-i]);
    compare_frame("R4");

    // R7: frame end with no data gives 16 zero tail symbols
    drive_slot(0, 1, 1);
    finish_frame(1'b0);
    @(posedge clk);
    chk(obs.size() == 16, "R7", "tail-only symbol count", obs.size(), 16);
    compare_frame("R7");

    // R9: idle slots inside a frame
    drive_slot(1, 1, 0); drive_slot(0, 1, 0); drive_slot(1, 1, 0);
    drive_slot(1, 0, 0); drive_slot(0, 0, 0); drive_slot(1, 1, 1);
    finish_frame(1'b1);
    compare_frame("R9");

    // R4/R5/R8: all 8-bit frames back to back, inputs toggled during flush
    for (int p = 0; p < 256; p++) begin
      for (int i = 0; i < 8; i++) drive_slot(1, p[7-i], i == 7);
      finish_frame(p[0]);
      compare_frame("R4");
      chk(m_hist == 8'h00, "R5", "model memory after flush", m_hist, 0);
    end

    report();
    $finish;
  end

endmodule